// File: doc/BRIEF.md
# Interrupt mask special register unit

This block keeps the exception-masking and control state of a small microcontroller-class core. It holds a one-bit interrupt mask, a one-bit fault mask, an 8-bit base priority and a 2-bit control field. The core reaches these registers through a numeric selector. A move-to-special-register instruction raises the write strobe with a data word. A move-from-special-register instruction raises the read strobe and takes the returned word.

Two selectors reach the base priority. The plain one overwrites it. The second one is conditional and can only tighten masking: a nonzero candidate is accepted when it is below the current value, or when the current value is zero. A zero base priority turns priority masking off. All mask state is driven on dedicated outputs for the exception logic. When a control write changes the stack-pointer select bit, a request is raised in the same cycle so that the core swaps its active stack pointer on the same edge.

Top module: `sreg_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released, the interrupt mask, fault mask, base priority and control are all zero. Zero means no masking and the main stack selected.
- R2: Selector 16 holds the interrupt mask. A write stores `wdata[0]`, and a read returns the mask in bit 0 with all other bits zero.
- R3: Selector 17 holds the base priority. A write stores `wdata[7:0]` unconditionally, and a read returns the 8-bit value zero-extended.
- R4: Selector 18 is the conditional base-priority alias. A write with candidate `wdata[7:0]` updates the base priority only when the candidate is nonzero and either is less than the current value or the current value is zero. Reads through selector 18 return the same value as selector 17.
- R5: Selector 19 holds the fault mask. A write stores `wdata[0]`, and a read returns it in bit 0.
- R6: Selector 20 holds the control field. A write stores `wdata[1:0]`, and a read returns those 2 bits zero-extended. Control bit 1 is the stack-pointer select.
- R7: `sp_switch_o` is high in exactly the cycles in which a selector-20 write carries a `wdata[1]` that differs from the current control bit 1.
- R8: Any other selector reads as zero, and a write to it leaves all state unchanged.
- R9: A write updates state on the rising clock edge at which `wr_en` is sampled high. `rdata` is combinational from the selector and the current state, and is zero whenever `rd_en` is low.
- R10: `irq_mask_o`, `flt_mask_o`, `base_pri_o` and `ctrl_o` always show the stored state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| sel | input | SEL_W (8) | Special register selector |
| wdata | input | DATA_W (32) | Write data word |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | DATA_W (32) | Read data, zero when `rd_en` is low |
| irq_mask_o | output | 1 | Current interrupt mask |
| flt_mask_o | output | 1 | Current fault mask |
| base_pri_o | output | PRI_W (8) | Current base priority, 0 = disabled |
| ctrl_o | output | CTRL_W (2) | Current control field |
| sp_switch_o | output | 1 | Request to swap the active stack pointer this cycle |

## Verification
Every piece of state is brought out on a dedicated port, so a wrong register value appears on the cycle right after the faulty write edge. The bench's per-clock comparison catches it there, without waiting for a readback. The most likely fault is a wrong comparison in the conditional alias. It shows up when `base_pri_o` either moves when it should stay or stays when it should move. The bench covers the larger, equal, zero, truncated-to-zero and current-zero cases. A decode slip shows up as a wrong `rdata` in the same cycle as the read. It can also show up as a change on an unrelated mask output one edge after a write. A fault in the swap request shows as an `sp_switch_o` value in the cycle of the control write that disagrees with the bit-1 transition.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

  localparam int SEL_IMASK    = 16;
  localparam int SEL_BPRI     = 17;
  localparam int SEL_BPRI_MAX = 18;
  localparam int SEL_FMASK    = 19;
  localparam int SEL_CTRL     = 20;

  localparam int CTRL_SP_BIT  = 1;

  typedef struct packed {
    logic imask;
    logic bpri;
    logic bpri_max;
    logic fmask;
    logic ctrl;
  } sreg_hit_t;

endpackage

// File: rtl/sreg_decode.sv
module sreg_decode
  import sreg_pkg::*;
#(
  parameter int SEL_W = 8
) (
  input  logic [SEL_W-1:0] sel,
  output sreg_hit_t        hit
);

  always_comb begin
    hit          = '0;
    hit.imask    = (sel == SEL_W'(SEL_IMASK));
    hit.bpri     = (sel == SEL_W'(SEL_BPRI));
    hit.bpri_max = (sel == SEL_W'(SEL_BPRI_MAX));
    hit.fmask    = (sel == SEL_W'(SEL_FMASK));
    hit.ctrl     = (sel == SEL_W'(SEL_CTRL));
  end

endmodule

// File: rtl/sreg_bpri.sv
module sreg_bpri #(
  parameter int PRI_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_plain,
  input  logic             wr_cond,
  input  logic [PRI_W-1:0] cand,
  output logic [PRI_W-1:0] bpri_q
);

  logic             tighten;
  logic             bpri_en;
  logic [PRI_W-1:0] bpri_d;

  // next-state: conditional alias only narrows the unmasked window
  always_comb begin
    tighten = (cand != '0) && ((bpri_q == '0) || (cand < bpri_q));
    bpri_en = wr_plain | (wr_cond & tighten);
    bpri_d  = cand;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bpri_q <= '0;
    end else if (bpri_en) begin
      bpri_q <= bpri_d;
    end
  end

endmodule

// File: rtl/sreg_flags.sv
module sreg_flags
  import sreg_pkg::*;
#(
  parameter int CTRL_W = 2,
  parameter int N_MASK = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_MASK-1:0] wr_mask,
  input  logic              mask_bit,
  input  logic              wr_ctrl,
  input  logic [CTRL_W-1:0] ctrl_data,
  output logic [N_MASK-1:0] mask_q,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              sp_switch
);

  for (genvar g = 0; g < N_MASK; g++) begin : g_mask
    logic mask_d;
    always_comb mask_d = mask_bit;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q[g] <= 1'b0;
      end else if (wr_mask[g]) begin
        mask_q[g] <= mask_d;
      end
    end
  end

  logic [CTRL_W-1:0] ctrl_d;

  always_comb begin
    ctrl_d    = ctrl_data;
    sp_switch = wr_ctrl && (ctrl_data[CTRL_SP_BIT] != ctrl_q[CTRL_SP_BIT]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q <= ctrl_d;
    end
  end

endmodule

// File: rtl/sreg_unit.sv
module sreg_unit
  import sreg_pkg::*;
#(
  parameter int SEL_W  = 8,
  parameter int DATA_W = 32,
  parameter int PRI_W  = 8,
  parameter int CTRL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_mask_o,
  output logic              flt_mask_o,
  output logic [PRI_W-1:0]  base_pri_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              sp_switch_o
);

  localparam int MASK_IRQ = 0;
  localparam int MASK_FLT = 1;
  localparam int N_MASK   = 2;

  sreg_hit_t         hit;
  logic [N_MASK-1:0] wr_mask;
  logic [N_MASK-1:0] mask_q;
  logic [PRI_W-1:0]  bpri_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [DATA_W-1:0] rd_mux;
  logic              unused_wdata_hi;

  assign unused_wdata_hi = ^wdata[DATA_W-1:PRI_W];

  sreg_decode #(.SEL_W(SEL_W)) u_dec (
    .sel (sel),
    .hit (hit)
  );

  always_comb begin
    wr_mask           = '0;
    wr_mask[MASK_IRQ] = wr_en & hit.imask;
    wr_mask[MASK_FLT] = wr_en & hit.fmask;
  end

  sreg_bpri #(.PRI_W(PRI_W)) u_bpri (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_plain (wr_en & hit.bpri),
    .wr_cond  (wr_en & hit.bpri_max),
    .cand     (wdata[PRI_W-1:0]),
    .bpri_q   (bpri_q)
  );

  sreg_flags #(.CTRL_W(CTRL_W), .N_MASK(N_MASK)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_mask   (wr_mask),
    .mask_bit  (wdata[0]),
    .wr_ctrl   (wr_en & hit.ctrl),
    .ctrl_data (wdata[CTRL_W-1:0]),
    .mask_q    (mask_q),
    .ctrl_q    (ctrl_q),
    .sp_switch (sp_switch_o)
  );

  always_comb begin
    rd_mux = '0;
    unique case (1'b1)
      hit.imask:               rd_mux = DATA_W'(mask_q[MASK_IRQ]);
      hit.bpri, hit.bpri_max:  rd_mux = DATA_W'(bpri_q);
      hit.fmask:               rd_mux = DATA_W'(mask_q[MASK_FLT]);
      hit.ctrl:                rd_mux = DATA_W'(ctrl_q);
      default:                 rd_mux = '0;
    endcase
    rdata = rd_en ? rd_mux : '0;
  end

  assign irq_mask_o = mask_q[MASK_IRQ];
  assign flt_mask_o = mask_q[MASK_FLT];
  assign base_pri_o = bpri_q;
  assign ctrl_o     = ctrl_q;

endmodule

// File: rtl/sreg_unit_chk.sv
module sreg_unit_chk
  import sreg_pkg::*;
#(
  parameter int SEL_W  = 8,
  parameter int DATA_W = 32,
  parameter int PRI_W  = 8,
  parameter int CTRL_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SEL_W-1:0]  sel,
  input logic [DATA_W-1:0] wdata,
  input logic              wr_en,
  input logic              rd_en,
  input logic [DATA_W-1:0] rdata,
  input logic              irq_mask_o,
  input logic              flt_mask_o,
  input logic [PRI_W-1:0]  base_pri_o,
  input logic [CTRL_W-1:0] ctrl_o,
  input logic              sp_switch_o
);

  logic             known;
  logic [PRI_W-1:0] cand;
  logic             unused_chk_hi;

  assign unused_chk_hi = ^wdata[DATA_W-1:PRI_W];
  assign cand  = wdata[PRI_W-1:0];
  assign known = (sel == SEL_W'(SEL_IMASK)) || (sel == SEL_W'(SEL_BPRI)) ||
                 (sel == SEL_W'(SEL_BPRI_MAX)) || (sel == SEL_W'(SEL_FMASK)) ||
                 (sel == SEL_W'(SEL_CTRL));

  assert_imask_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_W'(SEL_IMASK)) |=> (irq_mask_o == $past(wdata[0])));

  assert_bpri_wr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_W'(SEL_BPRI)) |=> (base_pri_o == $past(cand)));

  assert_bpri_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_W'(SEL_BPRI_MAX) &&
     (cand == '0 || (base_pri_o != '0 && cand >= base_pri_o))) |=> $stable(base_pri_o));

  assert_bpri_tighten_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_W'(SEL_BPRI_MAX) && cand != '0 &&
     (base_pri_o == '0 || cand < base_pri_o)) |=> (base_pri_o == $past(cand)));

  assert_fmask_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_W'(SEL_FMASK)) |=> (flt_mask_o == $past(wdata[0])));

  assert_ctrl_wr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_W'(SEL_CTRL)) |=> (ctrl_o == $past(wdata[CTRL_W-1:0])));

  assert_sp_switch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sp_switch_o |=> (ctrl_o[CTRL_SP_BIT] != $past(ctrl_o[CTRL_SP_BIT])));

  assert_unknown_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !known) |=> ($stable(irq_mask_o) && $stable(flt_mask_o) &&
                           $stable(base_pri_o) && $stable(ctrl_o)));

  assert_rd_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rdata == '0));

  assert_no_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(irq_mask_o) && $stable(flt_mask_o) &&
                $stable(base_pri_o) && $stable(ctrl_o)));

endmodule

bind sreg_unit sreg_unit_chk #(
  .SEL_W(SEL_W), .DATA_W(DATA_W), .PRI_W(PRI_W), .CTRL_W(CTRL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .wdata(wdata), .wr_en(wr_en),
  .rd_en(rd_en), .rdata(rdata), .irq_mask_o(irq_mask_o),
  .flt_mask_o(flt_mask_o), .base_pri_o(base_pri_o), .ctrl_o(ctrl_o),
  .sp_switch_o(sp_switch_o)
);

// File: tb/sim_sreg_unit.sv
`timescale 1ns/1ps
module sim_sreg_unit;

  logic        clk;
  logic        rst_n;
  logic [7:0]  sel;
  logic [31:0] wdata;
  logic        wr_en;
  logic        rd_en;
  logic [31:0] rdata;
  logic        irq_mask_o;
  logic        flt_mask_o;
  logic [7:0]  base_pri_o;
  logic [1:0]  ctrl_o;
  logic        sp_switch_o;

  sreg_unit u0 (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .irq_mask_o(irq_mask_o),
    .flt_mask_o(flt_mask_o), .base_pri_o(base_pri_o), .ctrl_o(ctrl_o),
    .sp_switch_o(sp_switch_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks   = 0;
  int failures = 0;
  bit running  = 0;
  bit finished = 0;

  // behavioural reference state
  int m_imask, m_fmask, m_bpri, m_ctrl;

  function automatic int ref_read(int s);
    case (s)
      16:      return m_imask;
      17, 18:  return m_bpri;
      19:      return m_fmask;
      20:      return m_ctrl;
      default: return 0;
    endcase
  endfunction

  function automatic void ref_write(int s, int d);
    int v;
    v = d & 'hff;
    case (s)
      16: m_imask = d & 1;
      17: m_bpri  = v;
      18: if (v != 0 && (m_bpri == 0 || v < m_bpri)) m_bpri = v;
      19: m_fmask = d & 1;
      20: m_ctrl  = d & 3;
      default: ;
    endcase
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison of the exposed state (R10)
  always @(negedge clk) begin
    if (running) begin
      chk("R10 irq_mask_o", irq_mask_o, m_imask);
      chk("R10 flt_mask_o", flt_mask_o, m_fmask);
      chk("R10 base_pri_o", base_pri_o, m_bpri);
      chk("R10 ctrl_o",     ctrl_o,     m_ctrl);
    end
  end

  task automatic op(string tag, bit w, bit r, int s, int d);
    int exp_sw;
    @(negedge clk);
    wr_en = w; rd_en = r; sel = 8'(s); wdata = 32'(d);
    #1;
    chk({tag, " rdata"}, rdata, r ? ref_read(s) : 0);
    exp_sw = (w && s == 20 && (((d >> 1) & 1) != ((m_ctrl >> 1) & 1))) ? 1 : 0;
    chk({"R7 sp_switch_o / ", tag}, sp_switch_o, exp_sw);
    @(posedge clk);
    if (w) ref_write(s, d);
    #1;
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    m_imask = 0; m_fmask = 0; m_bpri = 0; m_ctrl = 0;
    sel = '0; wdata = '0; wr_en = 1'b0; rd_en = 1'b0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 irq_mask", irq_mask_o, 0);
    chk("R1 flt_mask", flt_mask_o, 0);
    chk("R1 base_pri", base_pri_o, 0);
    chk("R1 ctrl",     ctrl_o,     0);
    rst_n = 1'b1;
    running = 1;

    op("R1 read ctrl after reset", 0, 1, 20, 0);
    op("R2 write imask", 1, 0, 16, 1);
    op("R2 read imask", 0, 1, 16, 0);
    op("R2 clear imask bit0", 1, 1, 16, 'hFFFFFFFE);
    op("R2 read imask", 0, 1, 16, 0);
    op("R3 write bpri", 1, 0, 17, 'h123456A5);
    op("R3 read bpri", 0, 1, 17, 0);
    op("R4 read alias", 0, 1, 18, 0);
    op("R4 larger ignored", 1, 0, 18, 'hB0);
    op("R4 truncated zero", 1, 0, 18, 'h100);
    op("R4 smaller taken", 1, 0, 18, 'h40);
    op("R4 equal ignored", 1, 0, 18, 'h40);
    op("R4 read alias", 0, 1, 18, 0);
    op("R3 clear bpri", 1, 0, 17, 0);
    op("R4 from zero", 1, 0, 18, 'hF0);
    op("R4 zero ignored", 1, 0, 18, 0);
    op("R3 raise bpri", 1, 0, 17, 'hFF);
    op("R4 read", 0, 1, 17, 0);
    op("R5 set fmask", 1, 0, 19, 3);
    op("R5 read fmask", 0, 1, 19, 0);
    op("R5 clear fmask", 1, 0, 19, 2);
    op("R5 read fmask", 0, 1, 19, 0);
    op("R6 write ctrl", 1, 0, 20, 'hFF);
    op("R6 read ctrl", 0, 1, 20, 0);
    op("R6 same sp", 1, 0, 20, 2);
    op("R6 read ctrl", 0, 1, 20, 0);
    op("R7 back to main", 1, 0, 20, 0);
    op("R7 keep main", 1, 0, 20, 1);
    op("R2 set imask", 1, 0, 16, 1);
    op("R5 set fmask", 1, 0, 19, 1);
    for (int k = 0; k < 6; k++) begin
      int s;
      s = (k == 0) ? 15 : (k == 1) ? 21 : (k == 2) ? 0 :
          (k == 3) ? 255 : (k == 4) ? 144 : 148;
      op("R8 unknown write", 1, 0, s, -1);
      op("R8 unknown read", 0, 1, s, 0);
    end
    op("R9 rd_en low imask", 0, 0, 16, 0);
    op("R9 rd_en low bpri", 0, 0, 17, 0);
    op("R9 write with read", 1, 1, 17, 'h22);
    op("R9 read new", 0, 1, 17, 0);
    @(negedge clk);
    running = 0;
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule